// File: doc/BRIEF.md
# AES-128 Round-Ahead Key Schedule Generator

This block produces the AES-128 round keys on the fly, one round per clock, in step with a cipher round controller. A load strobe captures a 128-bit cipher key, which appears at once as the round-0 key. On every following cycle the block presents the four 32-bit words of the next round key. It derives them from the words it currently shows, so no expanded-key storage is needed.

An internal round-constant sequencer advances with the same round counter. After round 10 the block returns to idle and keeps the last key on its outputs. A new key may be loaded in that final round cycle, so two encryptions can run back to back.

Top module: `rkey_expander`

## Requirements
- R1: While reset is held and directly after it, keyValid is 0, roundIdx is 0 and all four key words are 0.
- R2: When loadKey is 1 at a clock edge while idle, after that edge keyValid is 1, roundIdx is 0, keyW0 holds cipherKey[127:96], keyW1 holds [95:64], keyW2 holds [63:32] and keyW3 holds [31:0].
- R3: While valid, roundIdx rises by exactly one per clock from 0 to 10. A round-10 cycle without a load is followed by keyValid 0 with roundIdx still 10.
- R4: The new keyW0 is the old keyW0 XOR the round-constant word XOR the S-box image of the old keyW3 rotated left by one byte. Each new keyWi (i = 1..3) is the old keyWi XOR the new keyW(i-1).
- R5: The round-constant word has the constant in bits [31:24] and zeros below. The constants used for the steps into rounds 1 to 10 are 01, 02, 04, 08, 10, 20, 40, 80, 1B and 36, each the previous one doubled modulo x^8+x^4+x^3+x+1. Every load restarts the sequence at 01.
- R6: loadKey has no effect while roundIdx is 0 to 9 with keyValid 1.
- R7: loadKey during the round-10 cycle starts a new schedule at the next edge, with no idle cycle.
- R8: For cipher key 2b7e151628aed2a6abf7158809cf4f3c, the round-10 words are d014f9a8 c9ee2589 e13f0cc8 b6630ca6.
- R9: While idle with loadKey 0, the key words and roundIdx do not change, whatever cipherKey does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadKey | input | 1 | Start strobe; captures cipherKey when accepted |
| cipherKey | input | 128 | Cipher key, first key byte in bits [127:120] |
| keyW0 | output | 32 | Round-key word 0 of the current round |
| keyW1 | output | 32 | Round-key word 1 of the current round |
| keyW2 | output | 32 | Round-key word 2 of the current round |
| keyW3 | output | 32 | Round-key word 3 of the current round |
| roundIdx | output | 4 | Index of the round whose key is shown |
| keyValid | output | 1 | High from round 0 to round 10 of a schedule |

## Verification
The bound checker watches the sequencing rules on every cycle: the round index steps by one, loads are taken only when idle or in round 10, and the key words are captured at a load and held while idle. It also checks the linear part of the word chain, where each new word XOR its new left neighbour equals the old word. The S-box and round-constant part of the recurrence, and full key values such as the round-10 vector, are shown only by the bench. Its behavioural model recomputes the whole expanded key for each loaded key and compares every output on every clock. Its scenarios cover ignored mid-run loads, back-to-back loads and a reset during a run.

// File: rtl/rkey_pkg.sv
package rkey_pkg;
  localparam int BYTE_W         = 8;
  localparam int WORD_W         = 32;
  localparam int N_WORDS        = 4;
  localparam int KEY_W          = WORD_W * N_WORDS;
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
  localparam int N_ROUNDS       = 10;
  localparam int RND_W          = $clog2(N_ROUNDS + 1);
  localparam logic [BYTE_W-1:0] FIELD_POLY = 8'h1B;
  localparam logic [BYTE_W-1:0] RCON_INIT  = 8'h01;

  typedef struct packed {
    logic loadStb;
    logic stepStb;
  } ctrlStrobes_t;

  function automatic logic [BYTE_W-1:0] gfDouble(input logic [BYTE_W-1:0] a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? FIELD_POLY : '0);
  endfunction
endpackage

// File: rtl/rkey_sbox.sv
module rkey_sbox
  import rkey_pkg::*;
(
  input  logic [BYTE_W-1:0] inByte,
  output logic [BYTE_W-1:0] outByte
);
  localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;

  function automatic logic [BYTE_W-1:0] gfMul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc = '0;
    logic [BYTE_W-1:0] sh = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gfDouble(sh);
    end
    return acc;
  endfunction

  // a^254 equals the multiplicative inverse, and 0 maps to 0
  function automatic logic [BYTE_W-1:0] gfInv(input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] res = 8'h01;
    logic [BYTE_W-1:0] pw = a;
    for (int i = 1; i < BYTE_W; i++) begin
      pw  = gfMul(pw, pw);
      res = gfMul(res, pw);
    end
    return res;
  endfunction

  function automatic logic [BYTE_W-1:0] rotl(input logic [BYTE_W-1:0] v, input int n);
    return (v << n) | (v >> (BYTE_W - n));
  endfunction

  logic [BYTE_W-1:0] invByte;

  always_comb begin
    invByte = gfInv(inByte);
    outByte = invByte ^ rotl(invByte, 1) ^ rotl(invByte, 2) ^ rotl(invByte, 3)
            ^ rotl(invByte, 4) ^ AFFINE_C;
  end
endmodule

// File: rtl/rkey_ctrl.sv
module rkey_ctrl
  import rkey_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadKey,
  output ctrlStrobes_t     strobes,
  output logic [RND_W-1:0] roundIdx,
  output logic             keyValid
);
  typedef enum logic {ST_WAIT, ST_RUN} phase_t;
  localparam logic [RND_W-1:0] LAST_ROUND = RND_W'(N_ROUNDS);

  phase_t phase;
  logic   atLast;
  logic   canLoad;

  always_comb begin
    atLast          = (roundIdx == LAST_ROUND);
    canLoad         = (phase == ST_WAIT) || atLast;
    strobes.loadStb = loadKey && canLoad;
    strobes.stepStb = (phase == ST_RUN) && !atLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= ST_WAIT;
      roundIdx <= '0;
    end else if (strobes.loadStb) begin
      phase    <= ST_RUN;
      roundIdx <= '0;
    end else if (strobes.stepStb) begin
      roundIdx <= roundIdx + 1'b1;
    end else if (phase == ST_RUN) begin
      phase    <= ST_WAIT;
    end
  end

  assign keyValid = (phase == ST_RUN);
endmodule

// File: rtl/rkey_rcon.sv
module rkey_rcon
  import rkey_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [BYTE_W-1:0] rcon
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rcon <= RCON_INIT;
    else if (strobes.loadStb) rcon <= RCON_INIT;
    else if (strobes.stepStb) rcon <= gfDouble(rcon);
  end
endmodule

// File: rtl/rkey_datapath.sv
module rkey_datapath
  import rkey_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrlStrobes_t                     strobes,
  input  logic [BYTE_W-1:0]                rcon,
  input  logic [KEY_W-1:0]                 cipherKey,
  output logic [N_WORDS-1:0][WORD_W-1:0]   roundWords
);
  logic [N_WORDS-1:0][WORD_W-1:0] nextWords;
  logic [N_WORDS-1:0][WORD_W-1:0] loadWords;
  logic [WORD_W-1:0] rotWord;
  logic [WORD_W-1:0] subWord;
  logic [WORD_W-1:0] mixTerm;

  assign rotWord = {roundWords[N_WORDS-1][WORD_W-BYTE_W-1:0],
                    roundWords[N_WORDS-1][WORD_W-1 -: BYTE_W]};

  for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_sub
    rkey_sbox u_sbox (
      .inByte (rotWord[b*BYTE_W +: BYTE_W]),
      .outByte(subWord[b*BYTE_W +: BYTE_W])
    );
  end

  assign mixTerm      = subWord ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};
  assign nextWords[0] = roundWords[0] ^ mixTerm;

  for (genvar i = 1; i < N_WORDS; i++) begin : g_chain
    assign nextWords[i] = roundWords[i] ^ nextWords[i-1];
  end

  for (genvar i = 0; i < N_WORDS; i++) begin : g_load
    assign loadWords[i] = cipherKey[KEY_W-1-i*WORD_W -: WORD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                roundWords <= '0;
    else if (strobes.loadStb) roundWords <= loadWords;
    else if (strobes.stepStb) roundWords <= nextWords;
  end
endmodule

// File: rtl/rkey_expander.sv
module rkey_expander
  import rkey_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadKey,
  input  logic [KEY_W-1:0]  cipherKey,
  output logic [WORD_W-1:0] keyW0,
  output logic [WORD_W-1:0] keyW1,
  output logic [WORD_W-1:0] keyW2,
  output logic [WORD_W-1:0] keyW3,
  output logic [RND_W-1:0]  roundIdx,
  output logic              keyValid
);
  ctrlStrobes_t strobes;
  logic [BYTE_W-1:0] rcon;
  logic [N_WORDS-1:0][WORD_W-1:0] roundWords;

  rkey_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadKey (loadKey),
    .strobes (strobes),
    .roundIdx(roundIdx),
    .keyValid(keyValid)
  );

  rkey_rcon u_rcon (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .rcon   (rcon)
  );

  rkey_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rcon      (rcon),
    .cipherKey (cipherKey),
    .roundWords(roundWords)
  );

  assign keyW0 = roundWords[0];
  assign keyW1 = roundWords[1];
  assign keyW2 = roundWords[2];
  assign keyW3 = roundWords[3];
endmodule

// File: rtl/rkey_checker.sv
module rkey_checker
  import rkey_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              loadKey,
  input logic [KEY_W-1:0]  cipherKey,
  input logic [WORD_W-1:0] keyW0,
  input logic [WORD_W-1:0] keyW1,
  input logic [WORD_W-1:0] keyW2,
  input logic [WORD_W-1:0] keyW3,
  input logic [RND_W-1:0]  roundIdx,
  input logic              keyValid
);
  localparam logic [RND_W-1:0] LAST = RND_W'(N_ROUNDS);

  always_comb begin
    if (rstN) begin
      assert_round_range_R3: assert (roundIdx <= LAST);
    end
  end

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadKey && (!keyValid || roundIdx == LAST) |=>
      keyValid && roundIdx == '0 && {keyW0, keyW1, keyW2, keyW3} == $past(cipherKey));

  assert_round_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && roundIdx != LAST |=> keyValid && roundIdx == $past(roundIdx) + 1'b1);

  assert_end_to_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && roundIdx == LAST && !loadKey |=>
      !keyValid && roundIdx == LAST && $stable({keyW0, keyW1, keyW2, keyW3}));

  assert_chain_link_R4: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && roundIdx != LAST |=>
      (keyW1 ^ keyW0) == $past(keyW1) && (keyW2 ^ keyW1) == $past(keyW2)
      && (keyW3 ^ keyW2) == $past(keyW3));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !keyValid && !loadKey |=>
      !keyValid && $stable(roundIdx) && $stable({keyW0, keyW1, keyW2, keyW3}));
endmodule

bind rkey_expander rkey_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadKey  (loadKey),
  .cipherKey(cipherKey),
  .keyW0    (keyW0),
  .keyW1    (keyW1),
  .keyW2    (keyW2),
  .keyW3    (keyW3),
  .roundIdx (roundIdx),
  .keyValid (keyValid)
);

// File: tb/tb_rkey_expander.sv
`timescale 1ns/1ps
module tb_rkey_expander;
  logic         clk = 1'b0;
  logic         rstN;
  logic         loadKey = 1'b0;
  logic [127:0] cipherKey = '0;
  logic [31:0]  keyW0, keyW1, keyW2, keyW3;
  logic [3:0]   roundIdx;
  logic         keyValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  bit comparing = 0;

  always #10 clk = ~clk;

  rkey_expander dut (
    .clk(clk), .rstN(rstN), .loadKey(loadKey), .cipherKey(cipherKey),
    .keyW0(keyW0), .keyW1(keyW1), .keyW2(keyW2), .keyW3(keyW3),
    .roundIdx(roundIdx), .keyValid(keyValid)
  );

  localparam logic [127:0] KEY_A = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] KEY_B = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] KEY_C = 128'hffeeddccbbaa99887766554433221100;
  localparam logic [127:0] KEY_D = 128'h0;
  byte unsigned rconList[10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                                 8'h20, 8'h40, 8'h80, 8'h1B, 8'h36};

  // ---------------- reference arithmetic ----------------
  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    int prod = 0;
    for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (int'(a) << i);
    for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (32'h11B << (i - 8));
    return prod[7:0];
  endfunction

  function automatic logic [7:0] refSbox(input logic [7:0] x);
    logic [7:0] inv = 8'h00;
    logic [7:0] s;
    logic [7:0] c = 8'h63;
    for (int y = 1; y < 256; y++) if (refMul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return s;
  endfunction

  function automatic logic [31:0] refSubRot(input logic [31:0] w);
    logic [31:0] r = {w[23:0], w[31:24]};
    return {refSbox(r[31:24]), refSbox(r[23:16]), refSbox(r[15:8]), refSbox(r[7:0])};
  endfunction

  // ---------------- behavioural model ----------------
  logic [31:0] mSched [44];
  bit mValid = 0;
  bit mLoaded = 0;
  int mRound = 0;

  task automatic expandKey(input logic [127:0] k);
    for (int i = 0; i < 44; i++) begin
      if (i < 4) mSched[i] = k[127 - 32*i -: 32];
      else if (i % 4 == 0)
        mSched[i] = mSched[i-4] ^ refSubRot(mSched[i-1]) ^ {rconList[i/4 - 1], 24'h0};
      else mSched[i] = mSched[i-4] ^ mSched[i-1];
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mValid = 0; mLoaded = 0; mRound = 0;
    end else if (loadKey && (!mValid || mRound == 10)) begin
      expandKey(cipherKey);
      mValid = 1; mLoaded = 1; mRound = 0;
    end else if (mValid && mRound < 10) begin
      mRound = mRound + 1;
    end else if (mValid) begin
      mValid = 0;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] outWords();
    return {keyW0, keyW1, keyW2, keyW3};
  endfunction

  // per-cycle comparison against the model (R4 with R3/R5 folded in)
  always @(negedge clk) begin
    if (comparing && rstN) begin
      logic [127:0] expW;
      expW = mLoaded ? {mSched[4*mRound], mSched[4*mRound+1],
                        mSched[4*mRound+2], mSched[4*mRound+3]} : 128'h0;
      check("R4 model words", outWords(), expW);
      check("R3 model round/valid", {123'h0, roundIdx, keyValid},
            {123'h0, 4'(mRound), mValid});
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadPulse(input logic [127:0] k);
    cipherKey = k; loadKey = 1'b1;
    tick();
    loadKey = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [127:0] prevW;
    logic [127:0] held;
    rstN = 1'b1;
    #1 rstN = 1'b0;
    tick(2);
    check("R1 reset state", {outWords(), roundIdx, keyValid}, '0);
    rstN = 1'b1;
    tick();
    check("R1 after reset", {outWords(), roundIdx, keyValid}, '0);
    comparing = 1;

    // R2 + R5 + R8 on the known key
    loadPulse(KEY_A);
    check("R2 load words", outWords(), KEY_A);
    check("R2 round/valid", {roundIdx, keyValid}, {4'd0, 1'b1});
    for (int r = 1; r <= 10; r++) begin
      prevW = outWords();
      tick();
      check("R3 round step", {124'h0, roundIdx}, 128'(r));
      check("R5 rcon", {96'h0, keyW0 ^ prevW[127:96] ^ refSubRot(prevW[31:0])},
            {96'h0, rconList[r-1], 24'h0});
    end
    check("R8 round10 vector", outWords(), 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

    // R3 end of schedule, R9 idle hold with moving key input
    tick();
    check("R3 idle after round 10", {roundIdx, keyValid}, {4'd10, 1'b0});
    held = outWords();
    cipherKey = KEY_C;
    tick(3);
    cipherKey = KEY_B;
    tick(2);
    check("R9 idle hold", outWords(), held);
    check("R9 idle round", {roundIdx, keyValid}, {4'd10, 1'b0});

    // R6 load ignored mid-run
    loadPulse(KEY_B);
    tick(3);
    cipherKey = KEY_C; loadKey = 1'b1;
    tick();
    loadKey = 1'b0;
    check("R6 mid-run load ignored", {roundIdx, keyValid}, {4'd4, 1'b1});
    tick(6);
    check("R6 reached round 10", {roundIdx, keyValid}, {4'd10, 1'b1});

    // R7 back-to-back load in round 10
    cipherKey = KEY_D; loadKey = 1'b1;
    tick();
    loadKey = 1'b0;
    check("R7 back-to-back words", outWords(), KEY_D);
    check("R7 back-to-back round", {roundIdx, keyValid}, {4'd0, 1'b1});
    tick(10);
    check("R7 zero key round 10", outWords(), 128'hb4ef5bcb3e92e21123e951cf6f8f188e);

    // reset mid-run, then R5 restart of the constant on a fresh load
    tick(2);
    loadPulse(KEY_C);
    tick(4);
    rstN = 1'b0;
    tick();
    check("R1 reset mid-run", {outWords(), roundIdx, keyValid}, '0);
    rstN = 1'b1;
    tick();
    loadPulse(KEY_A);
    prevW = outWords();
    tick();
    check("R5 rcon restarts at 01", {96'h0, keyW0 ^ prevW[127:96] ^ refSubRot(prevW[31:0])},
          {96'h0, 8'h01, 24'h0});
    check("R4 round1 of known key", outWords(), 128'ha0fafe1788542cb123a339392a6c7605);
    tick(12);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule